// File: doc/BRIEF.md
# Nonvolatile Array Program/Erase Sequencer

This block holds the control word that software uses to program or erase an on-chip nonvolatile array, and runs the timed sequence that applies high voltage to the array. Software first sets the latch bit. While that bit is set, the next CPU writes into the array space are not performed as normal writes. The block captures their address and data as the program target, and the last write to a valid address wins. Software then sets the enable bit. If a target has been captured, the block raises the high-voltage enable for a fixed number of clock cycles and presents the decoded operation. The operation is one of byte program, byte erase, block erase, bulk erase, or none when the target block is protected.

Clearing the control bits is interlocked, so a sequence cannot be cut short. The latch bit cannot drop while the enable bit is set, and a write that clears both bits clears only the enable bit. Once the timed phase has started, requests to clear the enable bit or to change the mode are ignored. When the phase ends, the enable bit clears by itself if the auto-end bit is set. Otherwise it stays set, with high voltage off, until software clears it. A new cycle can start only after both bits have returned to 0.

Top module: `nvm_pe_seq`

## Requirements
- R1: Reset (rst_ni low) clears all control bits, the captured-target flag, busy_o and hv_en_o, and returns the sequencer to idle, including in the middle of a timed phase.
- R2: An array write is captured (cap_valid_o=1, pgm_addr_o/pgm_data_o updated, last one wins) only while the latch bit is 1 and no sequence has started, and only if the address is below ARR_DEPTH. The captured flag clears in the same cycle that the latch bit clears.
- R3: The latch bit (readback bit 0) cannot be cleared while the enable bit (readback bit 2) is 1. When the enable bit is 0, writing 0 to the latch bit clears it.
- R4: A single write of 0 to both the latch bit and the enable bit, made while the enable bit is 1 after the timed phase, clears only the enable bit. A second such write clears the latch bit.
- R5: Writing 1 to the enable bit starts a sequence only if the latch bit was already 1, is written as 1, and a target has been captured. Otherwise the enable bit stays 0 and busy_o stays low.
- R6: During the timed phase, writes that clear the enable or latch bit and writes to the auto-end bit (readback bit 1) or the mode bits (readback bits 4:3) have no effect.
- R7: For an unprotected target, hv_en_o is high for exactly PE_CYCLES consecutive cycles, starting in the cycle after the write that started the sequence.
- R8: When the timed phase ends with the auto-end bit set, the enable bit clears by itself. With the auto-end bit clear, the enable bit and busy_o stay high, with hv_en_o low, until software writes 0 to the enable bit.
- R9: op_mode_o decodes mode bits 00/01/10/11 to 0 (byte program), 1 (byte erase), 2 (block erase) and 3 (bulk erase). It reads 4 (no operation) when blk_prot_i is set for the captured address's block, which is the top BLK_IDX_W address bits. During the timed phase it holds the value fixed at the start.
- R10: With the target block protected, a start is accepted (busy_o goes high), the timed phase lasts one cycle, and hv_en_o is never asserted.
- R11: After a sequence has finished, writes that set the enable bit and array writes are ignored until the latch bit has been cleared.
- R12: busy_o equals the enable bit. reg_rdata_o returns {mode[1:0], enable, auto-end, latch} from bit 4 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 5 | Control write data {mode[1:0], enable, auto-end, latch} |
| reg_rdata_o | output | 5 | Control register readback, same layout |
| arr_we_i | input | 1 | CPU write into array space |
| arr_addr_i | input | ADDR_W | CPU array write address |
| arr_wdata_i | input | DATA_W | CPU array write data |
| blk_prot_i | input | 2**BLK_IDX_W | Per-block protect, one bit per block |
| hv_en_o | output | 1 | High-voltage enable to the array |
| op_mode_o | output | 3 | Decoded operation: 0 program, 1 byte erase, 2 block erase, 3 bulk erase, 4 none |
| pgm_addr_o | output | ADDR_W | Captured target address |
| pgm_data_o | output | DATA_W | Captured target data |
| cap_valid_o | output | 1 | A target has been captured |
| busy_o | output | 1 | Sequence started and enable bit not yet cleared |

## Verification
The bench builds the block with a 6-bit address, ARR_DEPTH of 48, four protect blocks and PE_CYCLES of 5. With a 6-bit address, all 64 addresses can be swept, including the 16 addresses beyond the valid range. With a 5-cycle phase, every combination of the four modes, the two end modes and protected or unprotected targets can be run to completion, with the high-voltage cycles counted exactly. The small bit count of the control word also lets each interlock be probed from every sequencer state.

// File: rtl/nvm_pe_pkg.sv
package nvm_pe_pkg;

  localparam int CTRL_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LATCHED = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_DONE    = 2'd3
  } seq_st_e;

  typedef enum logic [2:0] {
    OP_BYTE_PROG  = 3'd0,
    OP_BYTE_ERASE = 3'd1,
    OP_BLK_ERASE  = 3'd2,
    OP_BULK_ERASE = 3'd3,
    OP_NONE       = 3'd4
  } op_e;

  typedef struct packed {
    logic [1:0] mode;
    logic       pe;
    logic       auto_end;
    logic       lat;
  } ctrl_t;

  function automatic op_e decode_op(logic [1:0] mode, logic prot);
    op_e r;
    if (prot) begin
      r = OP_NONE;
    end else begin
      case (mode)
        2'd0:    r = OP_BYTE_PROG;
        2'd1:    r = OP_BYTE_ERASE;
        2'd2:    r = OP_BLK_ERASE;
        default: r = OP_BULK_ERASE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/nvm_pe_ctrl.sv
module nvm_pe_ctrl
  import nvm_pe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  ctrl_t      wdata_i,
  input  seq_st_e    st_i,
  input  logic       cap_valid_i,
  input  logic       fin_auto_i,
  output ctrl_t      ctrl_o,
  output logic [1:0] mode_nxt_o,
  output logic       start_o,
  output logic       lat_set_o,
  output logic       lat_clr_o
);

  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    start_o   = reg_we_i && wdata_i.pe && wdata_i.lat && !ctrl_q.pe && ctrl_q.lat &&
                (st_i == ST_LATCHED) && cap_valid_i;
    lat_set_o = reg_we_i && wdata_i.lat && !ctrl_q.lat;
    // latch may only drop once the enable bit is already low
    lat_clr_o = reg_we_i && !wdata_i.lat && ctrl_q.lat && !ctrl_q.pe;

    ctrl_d = ctrl_q;
    if (reg_we_i && (st_i != ST_ACTIVE)) begin
      ctrl_d.mode     = wdata_i.mode;
      ctrl_d.auto_end = wdata_i.auto_end;
    end
    if (lat_set_o)      ctrl_d.lat = 1'b1;
    else if (lat_clr_o) ctrl_d.lat = 1'b0;

    if (start_o) begin
      ctrl_d.pe = 1'b1;
    end else if (fin_auto_i || (reg_we_i && !wdata_i.pe && (st_i == ST_DONE))) begin
      ctrl_d.pe = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o     = ctrl_q;
  assign mode_nxt_o = ctrl_d.mode;

endmodule

// File: rtl/nvm_pe_capture.sv
module nvm_pe_capture
  import nvm_pe_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int ARR_DEPTH = 48,
  parameter int BLK_IDX_W = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  seq_st_e                   st_i,
  input  logic                      lat_clr_i,
  input  logic                      arr_we_i,
  input  logic [ADDR_W-1:0]         arr_addr_i,
  input  logic [DATA_W-1:0]         arr_wdata_i,
  input  logic [(1<<BLK_IDX_W)-1:0] blk_prot_i,
  output logic                      valid_o,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [DATA_W-1:0]         data_o,
  output logic                      prot_o
);

  localparam logic [ADDR_W:0] DEPTH_L = ARR_DEPTH[ADDR_W:0];

  logic                 valid_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    data_q;
  logic                 addr_ok;
  logic [BLK_IDX_W-1:0] blk_idx;

  assign addr_ok = ({1'b0, arr_addr_i} < DEPTH_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (lat_clr_i) begin
      valid_q <= 1'b0;
    end else if ((st_i == ST_LATCHED) && arr_we_i && addr_ok) begin
      valid_q <= 1'b1;
      addr_q  <= arr_addr_i;
      data_q  <= arr_wdata_i;
    end
  end

  assign blk_idx = addr_q[ADDR_W-1 -: BLK_IDX_W];
  assign prot_o  = blk_prot_i[blk_idx];
  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

endmodule

// File: rtl/nvm_pe_fsm.sv
module nvm_pe_fsm
  import nvm_pe_pkg::*;
#(
  parameter int PE_CYCLES = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lat_set_i,
  input  logic       lat_clr_i,
  input  logic       start_i,
  input  logic       prot_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] mode_nxt_i,
  input  logic       auto_i,
  output seq_st_e    st_o,
  output logic       hv_en_o,
  output logic       fin_auto_o,
  output op_e        op_mode_o
);

  localparam int TMR_W = $clog2(PE_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(PE_CYCLES - 1);

  seq_st_e          st_q, st_d;
  logic [TMR_W-1:0] tmr_q;
  op_e              op_q;
  logic             tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:    if (lat_set_i) st_d = ST_LATCHED;
      ST_LATCHED: begin
        if (start_i)        st_d = ST_ACTIVE;
        else if (lat_clr_i) st_d = ST_IDLE;
      end
      ST_ACTIVE:  if (tmr_zero) st_d = ST_DONE;
      ST_DONE:    if (lat_clr_i) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      op_q  <= OP_NONE;
    end else begin
      st_q <= st_d;
      if (start_i) begin
        // protected target: one-cycle phase, no voltage
        tmr_q <= prot_i ? '0 : TMR_LOAD;
        op_q  <= decode_op(mode_nxt_i, prot_i);
      end else if ((st_q == ST_ACTIVE) && !tmr_zero) begin
        tmr_q <= tmr_q - TMR_W'(1);
      end
    end
  end

  assign st_o       = st_q;
  assign hv_en_o    = (st_q == ST_ACTIVE) && (op_q != OP_NONE);
  assign fin_auto_o = (st_q == ST_ACTIVE) && tmr_zero && auto_i;
  assign op_mode_o  = (st_q == ST_ACTIVE) ? op_q : decode_op(mode_i, prot_i);

endmodule

// File: rtl/nvm_pe_seq.sv
module nvm_pe_seq
  import nvm_pe_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int ARR_DEPTH = 48,
  parameter int BLK_IDX_W = 2,
  parameter int PE_CYCLES = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_we_i,
  input  logic [CTRL_W-1:0]         reg_wdata_i,
  output logic [CTRL_W-1:0]         reg_rdata_o,
  input  logic                      arr_we_i,
  input  logic [ADDR_W-1:0]         arr_addr_i,
  input  logic [DATA_W-1:0]         arr_wdata_i,
  input  logic [(1<<BLK_IDX_W)-1:0] blk_prot_i,
  output logic                      hv_en_o,
  output logic [2:0]                op_mode_o,
  output logic [ADDR_W-1:0]         pgm_addr_o,
  output logic [DATA_W-1:0]         pgm_data_o,
  output logic                      cap_valid_o,
  output logic                      busy_o
);

  ctrl_t      wdata, ctrl;
  seq_st_e    st;
  op_e        op_mode;
  logic [1:0] mode_nxt;
  logic       start, lat_set, lat_clr, fin_auto, cap_valid, prot;

  assign wdata = ctrl_t'(reg_wdata_i);

  nvm_pe_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .wdata_i     (wdata),
    .st_i        (st),
    .cap_valid_i (cap_valid),
    .fin_auto_i  (fin_auto),
    .ctrl_o      (ctrl),
    .mode_nxt_o  (mode_nxt),
    .start_o     (start),
    .lat_set_o   (lat_set),
    .lat_clr_o   (lat_clr)
  );

  nvm_pe_capture #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ARR_DEPTH (ARR_DEPTH),
    .BLK_IDX_W (BLK_IDX_W)
  ) i_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .st_i        (st),
    .lat_clr_i   (lat_clr),
    .arr_we_i    (arr_we_i),
    .arr_addr_i  (arr_addr_i),
    .arr_wdata_i (arr_wdata_i),
    .blk_prot_i  (blk_prot_i),
    .valid_o     (cap_valid),
    .addr_o      (pgm_addr_o),
    .data_o      (pgm_data_o),
    .prot_o      (prot)
  );

  nvm_pe_fsm #(
    .PE_CYCLES (PE_CYCLES)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lat_set_i  (lat_set),
    .lat_clr_i  (lat_clr),
    .start_i    (start),
    .prot_i     (prot),
    .mode_i     (ctrl.mode),
    .mode_nxt_i (mode_nxt),
    .auto_i     (ctrl.auto_end),
    .st_o       (st),
    .hv_en_o    (hv_en_o),
    .fin_auto_o (fin_auto),
    .op_mode_o  (op_mode)
  );

  assign reg_rdata_o = ctrl;
  assign op_mode_o   = op_mode;
  assign cap_valid_o = cap_valid;
  assign busy_o      = ctrl.pe;

endmodule

// File: rtl/nvm_pe_seq_chk.sv
module nvm_pe_seq_chk #(
  parameter int PE_CYCLES = 5
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic       wd_lat_i,
  input logic [4:0] reg_rdata_o,
  input logic       hv_en_o,
  input logic       busy_o,
  input logic       cap_valid_o
);

  logic [31:0] hv_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hv_run <= '0;
    else if (hv_en_o) hv_run <= hv_run + 32'd1;
    else              hv_run <= '0;
  end

  // R3: latch held while enable is set
  p_lat_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && reg_we_i && !wd_lat_i |=> reg_rdata_o[0]);

  // R6: enable held through the phase in standard mode
  p_pe_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o && !reg_rdata_o[1] |=> reg_rdata_o[2]);

  // R5: voltage only with latch and captured target
  p_hv_cond_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o |-> busy_o && reg_rdata_o[0] && cap_valid_o);

  // R5: a start needs latch and target
  p_start_cond_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> reg_rdata_o[0] && cap_valid_o);

  // R7: phase never longer than PE_CYCLES
  p_hv_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o |-> hv_run < PE_CYCLES);

endmodule

bind nvm_pe_seq nvm_pe_seq_chk #(.PE_CYCLES(PE_CYCLES)) i_nvm_pe_seq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .wd_lat_i    (reg_wdata_i[0]),
  .reg_rdata_o (reg_rdata_o),
  .hv_en_o     (hv_en_o),
  .busy_o      (busy_o),
  .cap_valid_o (cap_valid_o)
);

// File: tb/test_nvm_pe_seq.sv
module test_nvm_pe_seq;

  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int ARR_DEPTH = 48;
  localparam int BLK_IDX_W = 2;
  localparam int PE_CYCLES = 5;

  logic                      clk = 1'b0;
  logic                      rst_ni;
  logic                      reg_we;
  logic [4:0]                reg_wdata;
  logic [4:0]                reg_rdata;
  logic                      arr_we;
  logic [ADDR_W-1:0]         arr_addr;
  logic [DATA_W-1:0]         arr_wdata;
  logic [(1<<BLK_IDX_W)-1:0] blk_prot;
  logic                      hv_en;
  logic [2:0]                op_mode;
  logic [ADDR_W-1:0]         pgm_addr;
  logic [DATA_W-1:0]         pgm_data;
  logic                      cap_valid;
  logic                      busy;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  nvm_pe_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_DEPTH(ARR_DEPTH),
    .BLK_IDX_W(BLK_IDX_W), .PE_CYCLES(PE_CYCLES)
  ) i_nvm_pe_seq (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .arr_we_i(arr_we), .arr_addr_i(arr_addr),
    .arr_wdata_i(arr_wdata), .blk_prot_i(blk_prot), .hv_en_o(hv_en),
    .op_mode_o(op_mode), .pgm_addr_o(pgm_addr), .pgm_data_o(pgm_data),
    .cap_valid_o(cap_valid), .busy_o(busy)
  );

  function automatic logic [4:0] pack(int mode, int pe, int au, int lat);
    return {mode[1:0], pe[0], au[0], lat[0]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic arr_wr(input int a, input int d);
    @(negedge clk);
    arr_we = 1'b1; arr_addr = a[ADDR_W-1:0]; arr_wdata = d[DATA_W-1:0];
    @(negedge clk);
    arr_we = 1'b0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_ni = 1'b0; reg_we = 1'b0; reg_wdata = '0; arr_we = 1'b0;
    arr_addr = '0; arr_wdata = '0; blk_prot = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 rdata", int'(reg_rdata), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 hv", int'(hv_en), 0);
    chk("R1 cap", int'(cap_valid), 0);
    chk("R9 op idle", int'(op_mode), 0);

    // R2: no capture in normal read mode
    arr_wr(3, 8'h11);
    chk("R2 no cap unlatched", int'(cap_valid), 0);

    // R5: latch and enable together do not start
    wr_reg(pack(0, 1, 0, 1));
    chk("R5 pe with lat set", int'(reg_rdata), int'(pack(0, 0, 0, 1)));
    chk("R5 busy", int'(busy), 0);
    // R5: no target yet
    wr_reg(pack(0, 1, 0, 1));
    chk("R5 no target", int'(busy), 0);
    arr_wr(50, 8'h22);
    chk("R2 invalid addr", int'(cap_valid), 0);
    wr_reg(pack(0, 1, 0, 1));
    chk("R5 invalid target", int'(busy), 0);

    // R2: full address sweep, last valid write wins
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      int ea;
      arr_wr(a, a ^ 8'h5A);
      ea = (a < ARR_DEPTH) ? a : ARR_DEPTH - 1;
      chk("R2 cap valid", int'(cap_valid), 1);
      chk("R2 cap addr", int'(pgm_addr), ea);
      chk("R2 cap data", int'(pgm_data), (ea ^ 8'h5A) & 8'hFF);
    end
    // R3: latch clears when enable low
    wr_reg(pack(0, 0, 0, 0));
    chk("R3 lat clear", int'(reg_rdata), 0);
    chk("R2 cap cleared", int'(cap_valid), 0);

    // Sweep modes x end modes x protection
    for (int au = 0; au < 2; au++) begin
      for (int m = 0; m < 4; m++) begin
        for (int p = 0; p < 2; p++) begin
          int b, a, eop, cnt;
          b = m % 3;
          a = b * 16 + 3 + m;
          blk_prot = p ? 4'(1 << b) : 4'(~(1 << b));
          eop = p ? 4 : m;
          wr_reg(pack(m, 0, au, 1));
          arr_wr(a, a + 7);
          chk("R2 cap", int'(pgm_addr), a);
          chk("R9 op live", int'(op_mode), eop);
          wr_reg(pack(m, 1, au, 1));
          chk("R12 busy on start", int'(busy), 1);
          chk("R12 rdata active", int'(reg_rdata), int'(pack(m, 1, au, 1)));
          chk("R9 op active", int'(op_mode), eop);
          cnt = 0;
          repeat (PE_CYCLES + 3) begin
            if (hv_en) cnt++;
            @(negedge clk);
          end
          if (p) chk("R10 no hv protected", cnt, 0);
          else   chk("R7 hv length", cnt, PE_CYCLES);
          if (au) begin
            chk("R8 auto clears pe", int'(reg_rdata), int'(pack(m, 0, 1, 1)));
            chk("R8 auto busy", int'(busy), 0);
            // R11: no restart, no capture before both bits clear
            arr_wr(a + 1, 0);
            wr_reg(pack(m, 1, 1, 1));
            chk("R11 no restart", int'(busy), 0);
            chk("R11 no capture", int'(pgm_addr), a);
            wr_reg(pack(0, 0, 0, 0));
            chk("R3 lat clear after auto", int'(reg_rdata), 0);
          end else begin
            chk("R8 std holds pe", int'(reg_rdata), int'(pack(m, 1, 0, 1)));
            chk("R8 std hv off", int'(hv_en), 0);
            wr_reg(pack(m, 0, 0, 0));
            chk("R4 only pe cleared", int'(reg_rdata), int'(pack(m, 0, 0, 1)));
            chk("R8 busy released", int'(busy), 0);
            wr_reg(pack(0, 0, 0, 0));
            chk("R4 second write clears lat", int'(reg_rdata), 0);
          end
          chk("R2 cap cleared", int'(cap_valid), 0);
        end
      end
    end
    blk_prot = '0;

    // R6: clear and mode change ignored mid-phase
    wr_reg(pack(2, 0, 0, 1));
    arr_wr(5, 9);
    wr_reg(pack(2, 1, 0, 1));
    wr_reg(pack(3, 0, 1, 0));
    chk("R6 ignored during phase", int'(reg_rdata), int'(pack(2, 1, 0, 1)));
    chk("R6 hv kept", int'(hv_en), 1);
    arr_wr(7, 1);
    chk("R2 no capture in phase", int'(pgm_addr), 5);
    repeat (PE_CYCLES + 2) @(negedge clk);
    chk("R8 std busy", int'(busy), 1);
    chk("R9 op after phase", int'(op_mode), 2);
    wr_reg(pack(0, 0, 0, 0));
    chk("R3 lat kept", int'(reg_rdata), int'(pack(0, 0, 0, 1)));
    wr_reg(pack(0, 0, 0, 0));
    chk("R4 lat cleared", int'(reg_rdata), 0);

    // R1: reset mid-phase
    wr_reg(pack(1, 0, 0, 1));
    arr_wr(9, 3);
    wr_reg(pack(1, 1, 0, 1));
    chk("R7 hv started", int'(hv_en), 1);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 hv reset", int'(hv_en), 0);
    chk("R1 rdata reset", int'(reg_rdata), 0);
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 cap reset", int'(cap_valid), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    report();
  end

endmodule